// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block decides, for a group of interrupt lines, whether a request should go to the processor and which line wins. It takes a pending vector and a mask vector and keeps its own in-service register. Ranking is relative to a programmable base offset. Rank 0 belongs to line `offset`, rank 1 to line `offset+1`, and so on, wrapping modulo the line count. A pending line raises the request only when it strictly outranks every line that is in service.

The control logic around the block decodes software commands into single-cycle strobes. These strobes cover acknowledge, non-specific end-of-interrupt (plain or rotating), specific end-of-interrupt, specific rotate and set-priority. Mode inputs select automatic end-of-interrupt, rotation on automatic end-of-interrupt, special mask mode and special fully nested mode. Special fully nested mode only has an effect when the block is built as the master of a cascade. The request and winning-line outputs are registered, so they follow the inputs and state by one clock.

Top module: `rot_prio_resolver`

## Requirements
- R1: While `rst` is high and after it is released, `isr_o` is 0, `irq_o` is 0, `line_o` is 0 and the offset is 0.
- R2: The unmasked pending set is `pend_i & ~mask_i`. Line L has rank (L - offset) mod 8. Among the unmasked pending lines, the one with the smallest rank wins. One clock later `line_o` shows that winner, and shows 0 when `irq_o` is low.
- R3: One clock after the inputs and state, `irq_o` is 1 exactly when the best pending rank is strictly smaller than the best in-service rank. An empty in-service set counts as rank 8. A pending line whose rank equals the in-service rank does not raise `irq_o`.
- R4: When `spec_mask_i` is 1, in-service bits whose `mask_i` bit is 1 are left out of the in-service rank.
- R5: When `nest_i` is 1 and the block is the master (`IS_MASTER`=1), in-service bit `CASCADE_LINE` (2) is left out of the in-service rank.
- R6: An `ack_i` pulse while a request is present sets the in-service bit of the current winner on the next clock. An `ack_i` pulse with no request present changes nothing.
- R7: An acknowledge with `auto_eoi_i`=1 leaves `isr_o` unchanged. If `rot_auto_eoi_i` is also 1, the offset becomes (winner + 1) mod 8.
- R8: `eoi_ns_i` clears the in-service bit with the smallest rank, judged on the whole in-service register. `eoi_ns_rot_i` also sets the offset to (that line + 1) mod 8. When no bit is in service, both change nothing.
- R9: `eoi_sp_i` clears in-service bit `sel_line_i`. `rot_sp_i` also sets the offset to (`sel_line_i` + 1) mod 8.
- R10: `set_prio_i` sets the offset to (`sel_line_i` + 1) mod 8 and leaves `isr_o` unchanged.
- R11: With no command strobe, `isr_o` and the offset hold their values. At most one strobe is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pend_i | input | 8 | Pending request vector |
| mask_i | input | 8 | Per-line mask, 1 = masked |
| spec_mask_i | input | 1 | Special mask mode enable |
| nest_i | input | 1 | Special fully nested mode enable |
| auto_eoi_i | input | 1 | Automatic end-of-interrupt on acknowledge |
| rot_auto_eoi_i | input | 1 | Rotate offset on automatic end-of-interrupt |
| ack_i | input | 1 | Acknowledge strobe |
| eoi_ns_i | input | 1 | Non-specific end-of-interrupt strobe |
| eoi_ns_rot_i | input | 1 | Rotating non-specific end-of-interrupt strobe |
| eoi_sp_i | input | 1 | Specific end-of-interrupt strobe |
| rot_sp_i | input | 1 | Specific rotate strobe |
| set_prio_i | input | 1 | Set-priority strobe |
| sel_line_i | input | 3 | Line operand for specific commands |
| irq_o | output | 1 | Registered interrupt request |
| line_o | output | 3 | Registered winning line |
| isr_o | output | 8 | In-service register |

## Verification
The bench builds the block with its default values: eight lines, master role, and cascade line 2. With this setup every offset and both special modes can be reached, including the exclusion of the cascade line. A long pseudo-random sequence drives pending, mask, mode and command inputs together. It walks the in-service register through many fill and drain patterns. After every cycle it compares the request, the winning line and the in-service register against an arithmetic ranking model. Directed steps cover the reset values, an end-of-interrupt on an empty in-service set, and a pending line whose rank ties with a line in service.

// File: rtl/rpr_pkg.sv
package rpr_pkg;
  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_ACK,
    CMD_EOI_NS,
    CMD_EOI_NS_ROT,
    CMD_EOI_SP,
    CMD_ROT_SP,
    CMD_SET_PRIO
  } rpr_cmd_e;
endpackage

// File: rtl/rpr_scan.sv
module rpr_scan #(
  parameter int NUM_LINES = 8,
  localparam int IDX_W = $clog2(NUM_LINES)
) (
  input  logic [NUM_LINES-1:0] vec_i,
  input  logic [IDX_W-1:0]     off_i,
  output logic                 found_o,
  output logic [IDX_W:0]       rank_o,
  output logic [IDX_W-1:0]     line_o
);
  always_comb begin
    logic [IDX_W-1:0] idx;
    rank_o = (IDX_W+1)'(NUM_LINES);
    line_o = '0;
    for (int p = NUM_LINES - 1; p >= 0; p--) begin
      idx = IDX_W'(p) + off_i;
      if (vec_i[idx]) begin
        rank_o = (IDX_W+1)'(p);
        line_o = idx;
      end
    end
    found_o = (rank_o != (IDX_W+1)'(NUM_LINES));
  end
endmodule

// File: rtl/rpr_state.sv
module rpr_state
  import rpr_pkg::*;
#(
  parameter int NUM_LINES = 8,
  localparam int IDX_W = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  rpr_cmd_e             cmd_i,
  input  logic                 ack_ok_i,
  input  logic [IDX_W-1:0]     ack_line_i,
  input  logic                 auto_eoi_i,
  input  logic                 rot_auto_eoi_i,
  input  logic                 ns_found_i,
  input  logic [IDX_W-1:0]     ns_line_i,
  input  logic [IDX_W-1:0]     sel_line_i,
  output logic [NUM_LINES-1:0] isr_q,
  output logic [IDX_W-1:0]     off_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      isr_q <= '0;
      off_q <= '0;
    end else begin
      case (cmd_i)
        CMD_ACK: begin
          if (ack_ok_i) begin
            if (!auto_eoi_i) isr_q[ack_line_i] <= 1'b1;
            else if (rot_auto_eoi_i) off_q <= ack_line_i + 1'b1;
          end
        end
        CMD_EOI_NS: begin
          if (ns_found_i) isr_q[ns_line_i] <= 1'b0;
        end
        CMD_EOI_NS_ROT: begin
          if (ns_found_i) begin
            isr_q[ns_line_i] <= 1'b0;
            off_q <= ns_line_i + 1'b1;
          end
        end
        CMD_EOI_SP: isr_q[sel_line_i] <= 1'b0;
        CMD_ROT_SP: begin
          isr_q[sel_line_i] <= 1'b0;
          off_q <= sel_line_i + 1'b1;
        end
        CMD_SET_PRIO: off_q <= sel_line_i + 1'b1;
        default: ;
      endcase
    end
  end

  // R6
  ack_sets_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_i == CMD_ACK && ack_ok_i && !auto_eoi_i) |=> isr_q[$past(ack_line_i)]);

  // R8
  eoi_empty_noop_chk: assert property (@(posedge clk) disable iff (rst)
    ((cmd_i == CMD_EOI_NS || cmd_i == CMD_EOI_NS_ROT) && isr_q == '0)
      |=> (isr_q == '0 && $stable(off_q)));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_i == CMD_NONE) |=> ($stable(isr_q) && $stable(off_q)));
endmodule

// File: rtl/rot_prio_resolver.sv
module rot_prio_resolver
  import rpr_pkg::*;
#(
  parameter int NUM_LINES    = 8,
  parameter bit IS_MASTER    = 1'b1,
  parameter int CASCADE_LINE = 2,
  localparam int IDX_W = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] pend_i,
  input  logic [NUM_LINES-1:0] mask_i,
  input  logic                 spec_mask_i,
  input  logic                 nest_i,
  input  logic                 auto_eoi_i,
  input  logic                 rot_auto_eoi_i,
  input  logic                 ack_i,
  input  logic                 eoi_ns_i,
  input  logic                 eoi_ns_rot_i,
  input  logic                 eoi_sp_i,
  input  logic                 rot_sp_i,
  input  logic                 set_prio_i,
  input  logic [IDX_W-1:0]     sel_line_i,
  output logic                 irq_o,
  output logic [IDX_W-1:0]     line_o,
  output logic [NUM_LINES-1:0] isr_o
);
  localparam logic [NUM_LINES-1:0] CASC_BIT = NUM_LINES'(1) << CASCADE_LINE;

  logic [NUM_LINES-1:0] isr_q, eff_pend, eff_isr, nest_excl;
  logic [IDX_W-1:0]     off_q, p_line, i_line, n_line;
  logic [IDX_W:0]       p_rank, i_rank, n_rank;
  logic                 p_found, i_found, n_found, req_c;
  rpr_cmd_e             cmd;
  logic                 irq_q;
  logic [IDX_W-1:0]     line_q;

  always_comb begin
    cmd = CMD_NONE;
    if (ack_i)             cmd = CMD_ACK;
    else if (eoi_ns_i)     cmd = CMD_EOI_NS;
    else if (eoi_ns_rot_i) cmd = CMD_EOI_NS_ROT;
    else if (eoi_sp_i)     cmd = CMD_EOI_SP;
    else if (rot_sp_i)     cmd = CMD_ROT_SP;
    else if (set_prio_i)   cmd = CMD_SET_PRIO;
  end

  generate
    if (IS_MASTER) begin : g_master
      assign nest_excl = nest_i ? CASC_BIT : '0;
    end else begin : g_slave
      assign nest_excl = '0;
    end
  endgenerate

  assign eff_pend = pend_i & ~mask_i;
  assign eff_isr  = isr_q & ~(spec_mask_i ? mask_i : '0) & ~nest_excl;

  rpr_scan #(.NUM_LINES(NUM_LINES)) pend_scan_i (
    .vec_i(eff_pend), .off_i(off_q), .found_o(p_found), .rank_o(p_rank), .line_o(p_line));
  rpr_scan #(.NUM_LINES(NUM_LINES)) serv_scan_i (
    .vec_i(eff_isr), .off_i(off_q), .found_o(i_found), .rank_o(i_rank), .line_o(i_line));
  rpr_scan #(.NUM_LINES(NUM_LINES)) eoi_scan_i (
    .vec_i(isr_q), .off_i(off_q), .found_o(n_found), .rank_o(n_rank), .line_o(n_line));

  assign req_c = p_found && (p_rank < i_rank);

  rpr_state #(.NUM_LINES(NUM_LINES)) state_i (
    .clk(clk), .rst(rst), .cmd_i(cmd), .ack_ok_i(req_c), .ack_line_i(p_line),
    .auto_eoi_i(auto_eoi_i), .rot_auto_eoi_i(rot_auto_eoi_i),
    .ns_found_i(n_found), .ns_line_i(n_line), .sel_line_i(sel_line_i),
    .isr_q(isr_q), .off_q(off_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q  <= 1'b0;
      line_q <= '0;
    end else begin
      irq_q  <= req_c;
      line_q <= req_c ? p_line : '0;
    end
  end

  assign irq_o  = irq_q;
  assign line_o = line_q;
  assign isr_o  = isr_q;

  // R11
  one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ack_i, eoi_ns_i, eoi_ns_rot_i, eoi_sp_i, rot_sp_i, set_prio_i}));

  // R3
  irq_needs_pend_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> ($past(eff_pend) != '0));

  // R7
  auto_eoi_keeps_isr_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_i && auto_eoi_i) |=> $stable(isr_o));

  // R10
  set_prio_keeps_isr_chk: assert property (@(posedge clk) disable iff (rst)
    set_prio_i |=> $stable(isr_o));

  // R2
  idle_line_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !irq_o |-> (line_o == '0));
endmodule

// File: tb/rot_prio_resolver_tb.sv
module rot_prio_resolver_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] pend_i = '0, mask_i = '0;
  logic       spec_mask_i = 0, nest_i = 0, auto_eoi_i = 0, rot_auto_eoi_i = 0;
  logic       ack_i = 0, eoi_ns_i = 0, eoi_ns_rot_i = 0, eoi_sp_i = 0, rot_sp_i = 0, set_prio_i = 0;
  logic [2:0] sel_line_i = '0;
  logic       irq_o;
  logic [2:0] line_o;
  logic [7:0] isr_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] m_isr = '0;
  int         m_off = 0;
  logic [31:0] rng = 32'h1234_5678;

  always #2 clk = ~clk;

  rot_prio_resolver dut_i (
    .clk(clk), .rst(rst), .pend_i(pend_i), .mask_i(mask_i),
    .spec_mask_i(spec_mask_i), .nest_i(nest_i), .auto_eoi_i(auto_eoi_i),
    .rot_auto_eoi_i(rot_auto_eoi_i), .ack_i(ack_i), .eoi_ns_i(eoi_ns_i),
    .eoi_ns_rot_i(eoi_ns_rot_i), .eoi_sp_i(eoi_sp_i), .rot_sp_i(rot_sp_i),
    .set_prio_i(set_prio_i), .sel_line_i(sel_line_i),
    .irq_o(irq_o), .line_o(line_o), .isr_o(isr_o));

  function automatic int best(logic [7:0] v, int off);
    for (int p = 0; p < 8; p++) if (v[(p + off) % 8]) return p;
    return 8;
  endfunction

  function automatic logic [31:0] next_rng(logic [31:0] x);
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_req(output bit req, output int ln);
    logic [7:0] ep, fi;
    int bp, bi;
    ep = pend_i & ~mask_i;
    fi = m_isr & ~(spec_mask_i ? mask_i : 8'h00) & ~(nest_i ? 8'h04 : 8'h00);
    bp = best(ep, m_off);
    bi = best(fi, m_off);
    req = bp < bi;
    ln  = req ? (bp + m_off) % 8 : 0;
  endtask

  function automatic string req_tag();
    if (nest_i && m_isr[2]) return "R5";
    if (spec_mask_i && (m_isr & mask_i) != 0) return "R4";
    if (m_isr != 0) return "R3";
    return "R2";
  endfunction

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit req;
    int ln, bn, cmd;
    string tag, itag;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 irq", irq_o, 0);
    chk("R1 isr", isr_o, 0);
    chk("R1 line", line_o, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 irq after release", irq_o, 0);

    // R8 non-specific EOI on empty in-service set
    eoi_ns_rot_i = 1; @(negedge clk); eoi_ns_rot_i = 0;
    pend_i = 8'h01; @(negedge clk);
    chk("R8 empty eoi isr", isr_o, 0);
    chk("R8 empty eoi offset line", line_o, 0);

    // R3 tie: line 3 in service, line 3 pending again -> no request
    pend_i = 8'h08; ack_i = 1; @(negedge clk); ack_i = 0; @(negedge clk);
    chk("R6 ack directed", isr_o, 8'h08);
    chk("R3 equal rank no irq", irq_o, 0);
    pend_i = 8'h04; @(negedge clk);
    chk("R3 higher rank irq", irq_o, 1);
    chk("R2 higher rank line", line_o, 2);
    eoi_sp_i = 1; sel_line_i = 3; @(negedge clk); eoi_sp_i = 0;
    pend_i = 8'h00; @(negedge clk);
    chk("R9 directed clear", isr_o, 0);
    m_isr = '0; m_off = 0;

    // random sweep with arithmetic model
    for (int it = 0; it < 6000; it++) begin
      rng = next_rng(rng);
      pend_i = rng[7:0];
      mask_i = rng[15:8] & rng[23:16];
      spec_mask_i = rng[24];
      nest_i = rng[25];
      auto_eoi_i = rng[26] & rng[27];
      rot_auto_eoi_i = rng[28];
      sel_line_i = rng[31:29];
      rng = next_rng(rng);
      cmd = rng % 10;
      model_req(req, ln);
      tag = req_tag();
      itag = "R11";
      case (cmd)
        0, 1, 2, 3: begin
          ack_i = 1;
          itag = auto_eoi_i ? "R7" : "R6";
          if (req) begin
            if (!auto_eoi_i) m_isr[ln] = 1'b1;
            else if (rot_auto_eoi_i) m_off = (ln + 1) % 8;
          end
        end
        4, 5: begin
          if (cmd == 4) eoi_ns_i = 1; else eoi_ns_rot_i = 1;
          itag = "R8";
          bn = best(m_isr, m_off);
          if (bn < 8) begin
            m_isr[(bn + m_off) % 8] = 1'b0;
            if (cmd == 5) m_off = ((bn + m_off) % 8 + 1) % 8;
          end
        end
        6: begin eoi_sp_i = 1; itag = "R9"; m_isr[sel_line_i] = 1'b0; end
        7: begin
          rot_sp_i = 1; itag = "R9";
          m_isr[sel_line_i] = 1'b0; m_off = (sel_line_i + 1) % 8;
        end
        8: begin set_prio_i = 1; itag = "R10"; m_off = (sel_line_i + 1) % 8; end
        default: ;
      endcase
      @(negedge clk);
      {ack_i, eoi_ns_i, eoi_ns_rot_i, eoi_sp_i, rot_sp_i, set_prio_i} = '0;
      chk({tag, " irq"}, irq_o, req);
      chk({tag, " line"}, line_o, ln);
      chk({itag, " isr"}, isr_o, m_isr);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule